// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block runs ahead of instruction execution in a 16-bit processor that uses segmented memory. It keeps a code-segment value and a 16-bit instruction offset and turns them into a 20-bit physical fetch address. It reads memory one 16-bit word at a time through a valid/ready request channel and a valid-only response channel. Each returned word goes into a six-byte queue. The decoder takes bytes out of that queue one at a time, and fetching continues while it does so.

A redirect (flush) input supplies a new segment and offset, for example after a taken jump. The redirect clears the queue and drops any read still in flight, and fetching resumes from the new location. After reset the unit stays idle until the first redirect gives it a start address.

Top module: `ipf_prefetch`

## Requirements
- R1: The fetch address on `memReqAddr` is (segment × 16 + offset) truncated to 20 bits, so a carry out of bit 19 is lost.
- R2: At most one read is outstanding. No request is raised while a read awaits its response. A request that waits for `memReqReady` keeps its address unchanged until it is accepted or a redirect arrives.
- R3: When the offset is even, both bytes of the returned word are queued, the low byte (bits 7:0) first, and the offset advances by 2.
- R4: When the offset is odd, only the high byte (bits 15:8) is queued and the offset advances by 1. Memory always returns the aligned word that holds the requested byte.
- R5: The offset wraps modulo 2^16 and the segment does not change. For example, offset FFFFh fetches one byte and then continues at offset 0000h.
- R6: The queue never holds more than 6 bytes, and with no pops it stops requesting once full.
- R7: `memReqValid` is high exactly when the unit is running, no read is pending, at least 2 byte slots are free and no redirect is present in that cycle.
- R8: In a redirect cycle `popValid` is low. From the next cycle the queue is empty, and later fetches use the new segment and offset.
- R9: A response to a read issued before a redirect is discarded, and no new request is raised until that response has come back.
- R10: Bytes leave in the order they were queued. A byte is removed only in a cycle where `popValid` and `popReq` are both high, and `popValid` is high whenever the queue is non-empty and no redirect is present.
- R11: During reset, and after it until the first redirect, the queue is empty and `memReqValid` is low.
- R12: A response and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flushValid | input | 1 | Redirect strobe |
| flushSeg | input | 16 | New code-segment value |
| flushOff | input | 16 | New instruction offset |
| memReqValid | output | 1 | Word read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 20 | Physical byte address of the fetch |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 16 | Aligned word, even byte in bits 7:0 |
| popValid | output | 1 | Queue head byte available |
| popReq | input | 1 | Decoder takes the head byte |
| popByte | output | 8 | Queue head byte |

## Verification
The hardest case to reach is a stale response: a redirect has to land while a read is pending, and the old data must then be kept out of the queue and must hold back the next request. The stimulus gets there by giving the bench memory a fixed long latency, raising the redirect in the cycle after acceptance, and then checking that the bytes queued afterwards all come from the new address. A long random run with variable latency and occasional redirects drives this case again alongside same-cycle pops and responses, and a cycle-accurate reference model checks every output on every clock.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic flush;   // redirect: clear queue, load segment/offset
    logic accept;  // take the current response into the queue
  } ipfStrobe_t;

  typedef enum logic [1:0] {
    FS_HALT  = 2'd0,
    FS_IDLE  = 2'd1,
    FS_WAIT  = 2'd2,
    FS_DRAIN = 2'd3
  } fetchState_t;
endpackage

// File: rtl/ipf_datapath.sv
module ipf_datapath
  import ipf_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int DEPTH = 6,
  parameter int ADDR_W = SEG_W + 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipfStrobe_t        ctl,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [SEG_W-1:0]  flushOff,
  input  logic [WORD_W-1:0] rspData,
  input  logic              popReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [CNT_W-1:0]  freeCnt,
  output logic              popValid,
  output logic [7:0]        popByte
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       qMem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic [SEG_W-1:0] segReg, offReg;
  logic             oddFetch, pushAny, pushTwo, doPop;
  logic [7:0]       firstByte;
  logic [CNT_W-1:0] pushCnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign oddFetch  = offReg[0];
  assign pushAny   = ctl.accept;
  assign pushTwo   = ctl.accept && !oddFetch;
  assign firstByte = oddFetch ? rspData[15:8] : rspData[7:0];
  assign pushCnt   = CNT_W'(pushAny) + CNT_W'(pushTwo);
  assign popValid  = (count != '0) && !ctl.flush;
  assign doPop     = popValid && popReq;
  assign popByte   = qMem[rdPtr];
  assign freeCnt   = CNT_W'(DEPTH) - count;
  assign fetchAddr = {segReg, 4'b0000} + ADDR_W'(offReg);

  always_ff @(posedge clk) begin
    if (pushAny) qMem[wrPtr] <= firstByte;
    if (pushTwo) qMem[bump(wrPtr)] <= rspData[15:8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      count  <= '0;
      segReg <= '0;
      offReg <= '0;
    end else if (ctl.flush) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      count  <= '0;
      segReg <= flushSeg;
      offReg <= flushOff;
    end else begin
      if (doPop) rdPtr <= bump(rdPtr);
      if (pushTwo)      wrPtr <= bump(bump(wrPtr));
      else if (pushAny) wrPtr <= bump(wrPtr);
      count <= count + pushCnt - CNT_W'(doPop);
      if (pushAny) offReg <= offReg + (oddFetch ? SEG_W'(1) : SEG_W'(2));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (count == '0)); // R8

  AST_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReq) |=> (ctl.flush || (popValid && $stable(popByte)))); // R10
endmodule

// File: rtl/ipf_control.sv
module ipf_control
  import ipf_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic [CNT_W-1:0] freeCnt,
  output logic             memReqValid,
  output ipfStrobe_t       ctl
);
  fetchState_t state, stateNext;

  assign memReqValid = (state == FS_IDLE) && (freeCnt >= CNT_W'(2)) && !flushValid;
  assign ctl.flush   = flushValid;
  assign ctl.accept  = (state == FS_WAIT) && memRspValid && !flushValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      FS_HALT:  if (flushValid) stateNext = FS_IDLE;
      FS_IDLE:  if (memReqValid && memReqReady) stateNext = FS_WAIT;
      FS_WAIT: begin
        if (memRspValid)     stateNext = FS_IDLE;
        else if (flushValid) stateNext = FS_DRAIN;
      end
      FS_DRAIN: if (memRspValid) stateNext = FS_IDLE;
      default:  stateNext = FS_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= FS_HALT;
    else       state <= stateNext;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid); // R2
endmodule

// File: rtl/ipf_prefetch.sv
module ipf_prefetch
  import ipf_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int QUEUE_DEPTH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [SEG_W-1:0]  flushOff,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [SEG_W+3:0]  memReqAddr,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic              popValid,
  input  logic              popReq,
  output logic [7:0]        popByte
);
  localparam int ADDR_W = SEG_W + 4;
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1);

  ipfStrobe_t       ctl;
  logic [CNT_W-1:0] freeCnt;

  ipf_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushValid(flushValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .freeCnt(freeCnt), .memReqValid(memReqValid), .ctl(ctl)
  );

  ipf_datapath #(.SEG_W(SEG_W), .DEPTH(QUEUE_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .flushSeg(flushSeg), .flushOff(flushOff),
    .rspData(memRspData), .popReq(popReq), .fetchAddr(memReqAddr),
    .freeCnt(freeCnt), .popValid(popValid), .popByte(popByte)
  );
endmodule

// File: tb/sim_ipf_prefetch.sv
`timescale 1ns/1ps
module sim_ipf_prefetch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushValid = 1'b0;
  logic [15:0] flushSeg = '0, flushOff = '0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [19:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [15:0] memRspData = '0;
  logic        popValid, popReq = 1'b0;
  logic [7:0]  popByte;

  always #2 clk = ~clk;

  ipf_prefetch u0 (.*);

  localparam int ST_HALT = 0, ST_IDLE = 1, ST_WAIT = 2, ST_DRAIN = 3;

  int nChecks = 0, nErr = 0, overlapSeen = 0;
  bit done = 0;

  logic [7:0]  mq[$];
  logic [15:0] mSeg = '0, mOff = '0;
  int          mState = ST_HALT;

  bit          memBusy = 0;
  int          memLat = 0, latMax = 0, latFix = 0;
  logic [19:0] memAddrW = '0;
  logic [19:0] reqLog[$];

  logic        lastReqValid, lastPopValid, prevHold = 0;
  logic [19:0] lastReqAddr, prevAddr = '0;
  logic [7:0]  lastPopByte;

  function automatic logic [7:0] memByte(input logic [19:0] a);
    logic [7:0] m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ {a[19:16], 4'hA};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic fl, input logic [15:0] sg, input logic [15:0] of,
                     input logic pr, input logic rdy);
    logic rspNow, expReq, expPv;
    logic [19:0] expAddr;
    @(negedge clk);
    flushValid = fl; flushSeg = sg; flushOff = of; popReq = pr; memReqReady = rdy;
    rspNow = memBusy && (memLat == 0);
    memRspValid = rspNow;
    memRspData = {memByte(memAddrW + 20'd1), memByte(memAddrW)};
    #1;
    expReq  = (mState == ST_IDLE) && ((6 - mq.size()) >= 2) && !fl;
    expAddr = {mSeg, 4'b0000} + {4'b0000, mOff};
    expPv   = (mq.size() > 0) && !fl;
    chk(memReqValid === expReq, "R7 memReqValid", 32'(memReqValid), 32'(expReq));
    if (expReq) chk(memReqAddr === expAddr, "R1 memReqAddr", 32'(memReqAddr), 32'(expAddr));
    chk(popValid === expPv, "R10 popValid", 32'(popValid), 32'(expPv));
    if (expPv) chk(popByte === mq[0], "R3 popByte", 32'(popByte), 32'(mq[0]));
    if (memBusy) chk(!memReqValid, "R2 request while pending", 32'(memReqValid), 32'd0);
    if (prevHold && memReqValid) chk(memReqAddr === prevAddr, "R2 held address", 32'(memReqAddr), 32'(prevAddr));
    lastReqValid = memReqValid; lastReqAddr = memReqAddr;
    lastPopValid = popValid;    lastPopByte = popByte;
    prevHold = memReqValid && !rdy; prevAddr = memReqAddr;
    @(posedge clk);
    if (fl) begin
      mq.delete(); mSeg = sg; mOff = of;
      if (mState == ST_WAIT || mState == ST_DRAIN) mState = rspNow ? ST_IDLE : ST_DRAIN;
      else mState = ST_IDLE;
    end else begin
      if (mState == ST_WAIT && rspNow && expPv && pr) overlapSeen++;
      if (expPv && pr) void'(mq.pop_front());
      case (mState)
        ST_IDLE:  if (expReq && rdy) mState = ST_WAIT;
        ST_WAIT:  if (rspNow) begin
          if (mOff[0]) begin
            mq.push_back(memRspData[15:8]); mOff = mOff + 16'd1;
          end else begin
            mq.push_back(memRspData[7:0]); mq.push_back(memRspData[15:8]); mOff = mOff + 16'd2;
          end
          mState = ST_IDLE;
        end
        ST_DRAIN: if (rspNow) mState = ST_IDLE;
        default: ;
      endcase
    end
    if (rspNow) memBusy = 0;
    else if (memBusy) memLat--;
    if (lastReqValid && rdy) begin
      memBusy = 1;
      memAddrW = {lastReqAddr[19:1], 1'b0};
      memLat = (latFix >= 0) ? latFix : int'($urandom_range(latMax, 0));
      reqLog.push_back(lastReqAddr);
    end
  endtask

  task automatic idle(input int n, input logic pr, input logic rdy);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 16'h0, pr, rdy);
  endtask

  initial begin
    #700000;
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!memReqValid && !popValid, "R11 during reset", {memReqValid, popValid}, 0);
    rstN = 1'b1;
    idle(3, 1'b1, 1'b1);
    chk(!lastReqValid && !lastPopValid, "R11 idle before redirect", {lastReqValid, lastPopValid}, 0);

    // R1: 2000:0450 fetch, fill without popping
    latFix = 0;
    cyc(1'b1, 16'h2000, 16'h0450, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 16'h0, 1'b0, 1'b1);
    chk(lastReqValid && lastReqAddr == 20'h20450, "R1 first address", lastReqAddr, 20'h20450);
    idle(30, 1'b0, 1'b1);
    chk(!lastReqValid, "R6 full queue stops requests", lastReqValid, 0);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 16'h0, 16'h0, 1'b1, 1'b0);
      chk(lastPopValid && lastPopByte == memByte(20'h20450 + 20'(i)), "R3 even-order byte",
          lastPopByte, memByte(20'h20450 + 20'(i)));
    end

    // R8 redirect with bytes queued; R4 odd start
    idle(8, 1'b0, 1'b1);
    cyc(1'b1, 16'h2000, 16'h0451, 1'b1, 1'b1);
    chk(!lastPopValid, "R8 popValid low in redirect cycle", lastPopValid, 0);
    cyc(1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    chk(!lastPopValid, "R8 queue empty after redirect", lastPopValid, 0);
    idle(30, 1'b0, 1'b1);
    chk(!lastReqValid, "R7 no request with one free slot", lastReqValid, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 16'h0, 16'h0, 1'b1, 1'b0);
      chk(lastPopValid && lastPopByte == memByte(20'h20451 + 20'(i)), "R4 odd-start byte",
          lastPopByte, memByte(20'h20451 + 20'(i)));
    end

    // R5 offset wrap inside the segment
    reqLog.delete();
    cyc(1'b1, 16'h1000, 16'hFFFF, 1'b0, 1'b0);
    idle(10, 1'b0, 1'b1);
    chk(reqLog.size() >= 2 && reqLog[0] == 20'h1FFFF, "R5 address at offset FFFF", reqLog[0], 20'h1FFFF);
    chk(reqLog.size() >= 2 && reqLog[1] == 20'h10000, "R5 offset wraps to 0000", reqLog[1], 20'h10000);

    // R1 physical wrap past 1 MB
    cyc(1'b1, 16'hFFFF, 16'h0020, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    chk(lastReqValid && lastReqAddr == 20'h00010, "R1 carry beyond bit 19 dropped", lastReqAddr, 20'h00010);

    // R9 stale response after redirect
    latFix = 5;
    cyc(1'b1, 16'h3000, 16'h0000, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 16'h0, 1'b0, 1'b1);
    cyc(1'b1, 16'h4000, 16'h0000, 1'b0, 1'b1);
    cyc(1'b0, 16'h0, 16'h0, 1'b0, 1'b1);
    chk(!lastReqValid, "R9 no request while stale read pending", lastReqValid, 0);
    latFix = 0;
    idle(30, 1'b0, 1'b1);
    for (int i = 0; i < 2; i++) begin
      cyc(1'b0, 16'h0, 16'h0, 1'b1, 1'b0);
      chk(lastPopValid && lastPopByte == memByte(20'h40000 + 20'(i)), "R9 only new-address bytes",
          lastPopByte, memByte(20'h40000 + 20'(i)));
    end

    // random overlap run
    latFix = -1; latMax = 3;
    for (int i = 0; i < 4000; i++) begin
      logic fl = ($urandom_range(99, 0) < 2);
      cyc(fl, 16'($urandom), 16'($urandom), 1'($urandom), ($urandom_range(9, 0) < 6));
    end
    chk(overlapSeen > 0, "R12 pop and response in one cycle", overlapSeen, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule